// File: doc/BRIEF.md
# Stopped-Clock SPI Master Port

This block is a synchronous serial port that acts as an SPI master toward an external serial bridge device. Transmit and receive share one shift clock and one frame strobe. The frame strobe is the active-low slave select. The shift clock toggles only while a word is on the wire and rests low between words. Software controls the port through a small four-register bus. One control word holds separate enables for the transmit section, the receive section and the rate generator, plus a clock-phase choice and a divider. When the rate generator is enabled it first runs a short synchronisation interval, and the port accepts no transfer until that interval ends.

A write to the transmit register starts a transfer when the port is idle and ready. Slave select drops at once. The port then waits one full bit time before the first data bit appears, so the frame is asserted ahead of the data. Sixteen bits follow, most significant first. The received word is captured from MISO at the middle of each bit and presented in the receive register with a ready flag.

All timing is counted in half-bit ticks. A tick occurs every DIV+1 system clocks, where DIV is the divider field. One bit time is two ticks.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, slave select is high, and SCK and MOSI are low.
- R2: Control register (address 0) fields are: bit 0 transmit enable, bit 1 receive enable, bit 2 rate-generator enable, bit 3 late start, bits 15:8 DIV. When bit 2 is set, status bit 2 (port ready) rises 4*(DIV+1) clocks after the write edge. A write to the transmit register (address 2) starts nothing while port ready is low or transmit enable is 0. Slave select stays high whenever port ready is low.
- R3: A transmit write while the port is idle and ready pulls slave select low in the next cycle. The written word then leaves on MOSI, most significant bit first, 16 bits.
- R4: When slave select falls, SCK and MOSI are both low. The first SCK transition comes 2*(DIV+1) clocks later with late start = 0, and 3*(DIV+1) clocks later with late start = 1.
- R5: Each frame has exactly 16 SCK pulses, and slave select stays low for 34*(DIV+1) clocks. SCK and MOSI stay low between frames.
- R6: With late start = 0, SCK rises as each bit is presented and the bit is sampled on the falling edge. With late start = 1, SCK rises half a bit later and the bit is sampled on the rising edge.
- R7: MISO is sampled at mid-bit and assembled MSB first. When slave select rises at the end of a frame with receive enabled, the receive register (address 3) holds the word and status bit 1 (receive ready) is set.
- R8: A read of the receive register clears receive ready.
- R9: While receive enable is 0, receive ready stays 0 and the receive register keeps its value, but transfers still run.
- R10: A transmit write during a frame is ignored. The frame in progress is unchanged and no further frame follows.
- R11: Clearing the rate-generator enable drops port ready and ends any frame in progress (slave select high) one cycle after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on receive register) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 transmit, 3 receive |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |
| spi_sck | output | 1 | Shift clock, low at rest |
| spi_ss_n | output | 1 | Frame strobe used as active-low slave select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong step or tick counter shows first as a shifted SCK lead after slave select falls, or as a frame whose length differs from 34 ticks. Both are visible within the first bit time or at the end of that same frame. A broken bit index or sampling phase garbles the word captured by the slave model on MOSI, or the word read back from MISO. The error appears as soon as that frame closes. Faults in the enables and the ready flag show as frames that should not start, or that fail to stop, within one tick of the control write that governs them.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  localparam int REG_W = 16;
  localparam int DIV_W = 8;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_TXD  = 2'd2,
    RA_RXD  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [3:0]       spare;
    logic             late;
    logic             gen_on;
    logic             rx_on;
    logic             tx_on;
  } ctrl_t;

  // Last half-bit step of a frame: one bit of lead plus two steps per bit.
  function automatic int unsigned frame_last(input int unsigned w);
    return 2 * w + 2;
  endfunction

  // SCK level during a given step. Immediate mode is high on even data
  // steps; late mode is high on odd data steps.
  function automatic logic sck_level(input logic late, input int unsigned step,
                                     input int unsigned w);
    if (step < 2 || step >= frame_last(w)) return 1'b0;
    return (step[0] == late);
  endfunction

  // Word bit presented on MOSI during a data step.
  function automatic int unsigned bit_pos(input int unsigned step, input int unsigned w);
    return w - 1 - ((step - 2) / 2);
  endfunction

  // A tick leaving this step enters a mid-bit step, where MISO is taken.
  function automatic logic is_sample_step(input int unsigned step, input int unsigned w);
    return (step >= 2) && (step <= 2 * w) && (step[0] == 1'b0);
  endfunction

endpackage

// File: rtl/spi_cs_clkgen.sv
module spi_cs_clkgen
  import spi_cs_pkg::*;
#(
  parameter int SYNC_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_on,
  input  logic             restart,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_live,
  output logic             tick,
  output logic             port_ready
);
  localparam int SYNC_TICKS = 2 * SYNC_BITS;
  localparam int SCW        = $clog2(SYNC_TICKS + 1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_eff;
  logic [SCW-1:0]   sync_q;

  // While a frame runs, the divider captured at its start is used.
  assign div_eff = hold ? div_q : div_live;
  assign tick    = gen_on && (cnt_q == div_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      if (!hold) div_q <= div_live;
      if (!gen_on || restart || tick) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q     <= '0;
      port_ready <= 1'b0;
    end else if (!gen_on) begin
      sync_q     <= '0;
      port_ready <= 1'b0;
    end else if (tick && !port_ready) begin
      sync_q <= sync_q + 1'b1;
      if (sync_q == SCW'(SYNC_TICKS - 1)) port_ready <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter
  import spi_cs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              abort,
  input  logic              late_in,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              ss_n,
  output logic              sck,
  output logic              mosi,
  output logic              word_done,
  output logic              sample_en,
  output logic [WORD_W-1:0] rx_word
);
  localparam int LAST = 2 * WORD_W + 2;
  localparam int SW   = $clog2(LAST + 1);
  localparam int IW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [SW-1:0]     step_q;
  logic              busy_q;
  logic              late_q;
  logic [WORD_W-1:0] txw_q;
  logic [WORD_W-1:0] rxsh_q;
  int unsigned       step_i;
  logic [IW-1:0]     bidx;
  logic              in_data;
  logic              end_step;
  logic              advance;

  assign step_i    = 32'(step_q);
  assign in_data   = busy_q && (step_q >= SW'(2)) && (step_q < SW'(LAST));
  assign bidx      = IW'(bit_pos(step_i, WORD_W));
  assign end_step  = (step_q == SW'(LAST - 1));
  assign advance   = busy_q && tick && !abort;
  assign sample_en = advance && is_sample_step(step_i, WORD_W);
  assign word_done = advance && end_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      late_q <= 1'b0;
      txw_q  <= '0;
      rxsh_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      step_q <= '0;
      late_q <= late_in;
      txw_q  <= tx_word;
    end else if (advance) begin
      if (end_step) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
      if (sample_en) rxsh_q <= {rxsh_q[WORD_W-2:0], miso};
    end
  end

  assign busy    = busy_q;
  assign ss_n    = !busy_q;
  assign sck     = busy_q && sck_level(late_q, step_i, WORD_W);
  assign mosi    = in_data && txw_q[bidx];
  assign rx_word = rxsh_q;

endmodule

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
  import spi_cs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              port_ready,
  input  logic              word_done,
  input  logic [WORD_W-1:0] rx_word,
  output ctrl_t             ctrl,
  output logic              tx_wr,
  output logic [WORD_W-1:0] tx_word,
  output logic              rd_rx,
  output logic              rx_ready,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [WORD_W-1:0] rx_data_q;
  logic [REG_W-1:0]  rx_ext;
  logic [REG_W-1:0]  stat;

  assign tx_wr   = reg_wr && (reg_addr == RA_TXD);
  assign tx_word = reg_wdata[WORD_W-1:0];
  assign rd_rx   = reg_rd && (reg_addr == RA_RXD);

  always_ff @(posedge clk) begin
    if (!rst_n)                             ctrl <= '0;
    else if (reg_wr && reg_addr == RA_CTRL) ctrl <= ctrl_t'(reg_wdata);
  end

  // A completed word takes priority over a clearing read in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ready  <= 1'b0;
      rx_data_q <= '0;
    end else if (!ctrl.rx_on) begin
      rx_ready <= 1'b0;
    end else if (word_done) begin
      rx_ready  <= 1'b1;
      rx_data_q <= rx_word;
    end else if (rd_rx) begin
      rx_ready <= 1'b0;
    end
  end

  always_comb begin
    rx_ext = '0;
    rx_ext[WORD_W-1:0] = rx_data_q;
    stat = '0;
    stat[0] = busy;
    stat[1] = rx_ready;
    stat[2] = port_ready;
    unique case (reg_addr)
      RA_CTRL: reg_rdata = ctrl;
      RA_STAT: reg_rdata = stat;
      RA_TXD:  reg_rdata = '0;
      default: reg_rdata = rx_ext;
    endcase
  end

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SYNC_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             spi_sck,
  output logic             spi_ss_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  ctrl_t             ctrl;
  logic              tx_on, rx_on, gen_on;
  logic              tick, port_ready, busy;
  logic              tx_wr, rd_rx, rx_ready;
  logic              start_xfer, abort_xfer;
  logic              word_done, sample_en;
  logic [WORD_W-1:0] tx_word, rx_word;

  assign tx_on      = ctrl.tx_on;
  assign rx_on      = ctrl.rx_on;
  assign gen_on     = ctrl.gen_on;
  assign start_xfer = tx_wr && !busy && port_ready && tx_on;
  assign abort_xfer = !gen_on || !tx_on;

  spi_cs_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
    .port_ready(port_ready), .word_done(word_done), .rx_word(rx_word),
    .ctrl(ctrl), .tx_wr(tx_wr), .tx_word(tx_word), .rd_rx(rd_rx),
    .rx_ready(rx_ready), .reg_rdata(reg_rdata)
  );

  spi_cs_clkgen #(.SYNC_BITS(SYNC_BITS)) u_gen (
    .clk(clk), .rst_n(rst_n), .gen_on(gen_on), .restart(start_xfer),
    .hold(busy), .div_live(ctrl.div), .tick(tick), .port_ready(port_ready)
  );

  spi_cs_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_xfer),
    .abort(abort_xfer), .late_in(ctrl.late), .tx_word(tx_word),
    .miso(spi_miso), .busy(busy), .ss_n(spi_ss_n), .sck(spi_sck),
    .mosi(spi_mosi), .word_done(word_done), .sample_en(sample_en),
    .rx_word(rx_word)
  );

endmodule

// File: rtl/spi_cs_checker.sv
module spi_cs_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic word_done,
  input logic busy,
  input logic port_ready,
  input logic rx_ready,
  input logic tx_on,
  input logic rx_on,
  input logic gen_on,
  input logic rd_rx,
  input logic spi_sck,
  input logic spi_ss_n,
  input logic spi_mosi
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_n |-> (!spi_sck && !spi_mosi)); // R5

  AST_NOT_READY_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !port_ready |-> spi_ss_n); // R2

  AST_FRAME_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_ss_n) |-> (!spi_sck && !spi_mosi)); // R4

  AST_SCK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && tx_on && gen_on) |=> $stable(spi_sck)); // R5

  AST_DONE_FLAGS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_on) |=> rx_ready); // R7

  AST_READ_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !word_done) |=> !rx_ready); // R8

  AST_RX_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> !rx_ready); // R9

  AST_GEN_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_on |=> (!port_ready && spi_ss_n)); // R11

endmodule

bind spi_cs_master spi_cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .word_done(word_done),
  .busy(busy), .port_ready(port_ready), .rx_ready(rx_ready),
  .tx_on(tx_on), .rx_on(rx_on), .gen_on(gen_on), .rd_rx(rd_rx),
  .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi)
);

// File: tb/sim_spi_cs_master.sv
module sim_spi_cs_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        spi_sck, spi_ss_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_cs_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  typedef struct {
    logic [15:0] word;
    int          lead;
    int          len;
  } exp_t;
  exp_t q[$];

  int          cur_div = 0;
  bit          cur_late = 0;
  bit          abort_frame = 0;
  logic [15:0] slv_word = 16'h0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; the write is taken at the next rising edge.
  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ctrl(input logic [15:0] v);
    cur_div  = int'(v[15:8]);
    cur_late = v[3];
    reg_write(2'd0, v);
  endtask

  // Monitor and slave model: everything is sampled at falling edges.
  logic        prev_ss = 1'b1, prev_sck = 1'b0;
  int          len = 0, lead = 0, edges = 0;
  bit          got_first = 0, idle_bad = 0, fr_late = 0;
  logic [15:0] cap = 16'h0, slv_sh = 16'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ss && !spi_ss_n) begin
        len = 1; lead = 0; edges = 0; got_first = 0; cap = 16'h0;
        fr_late = cur_late;
        slv_sh = slv_word;
        spi_miso = slv_word[15];
        if (spi_sck || spi_mosi) idle_bad = 1;
      end else if (!spi_ss_n) begin
        len++;
        if (!got_first && spi_sck != prev_sck) begin
          got_first = 1;
          lead = len - 1;
        end
        if (fr_late ? (!prev_sck && spi_sck) : (prev_sck && !spi_sck)) begin
          cap = {cap[14:0], spi_mosi};
          edges++;
          slv_sh = {slv_sh[14:0], 1'b0};
          spi_miso = slv_sh[15];
        end
      end else if (!prev_ss && spi_ss_n) begin
        spi_miso = 1'b0;
        if (abort_frame) begin
          abort_frame = 0;
        end else if (q.size() == 0) begin
          chk("R10 unexpected frame", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R3 R6 mosi word", {16'h0, cap}, {16'h0, e.word});
          chk("R5 sck pulses", edges, 16);
          chk("R4 sck lead", lead, e.lead);
          chk("R5 frame length", len, e.len);
          chk("R5 idle quiet", {31'h0, idle_bad}, 32'd0);
        end
        idle_bad = 0;
      end else begin
        if (spi_sck || spi_mosi) idle_bad = 1;
      end
      prev_ss = spi_ss_n;
      prev_sck = spi_sck;
    end
  end

  task automatic wait_idle();
    while (!spi_ss_n) @(negedge clk);
  endtask

  // Driver: queue the expected frame, start it, then check the receive side.
  task automatic send(input logic [15:0] w, input logic [15:0] sw, input bit rx_exp,
                      input logic [15:0] rx_old, input bit poke_busy);
    exp_t e;
    logic [15:0] r;
    e.word = w;
    e.lead = (cur_late ? 3 : 2) * (cur_div + 1);
    e.len  = 34 * (cur_div + 1);
    q.push_back(e);
    slv_word = sw;
    reg_write(2'd2, w);
    chk("R3 ss low after write", {31'h0, spi_ss_n}, 32'd0);
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      reg_write(2'd2, ~w);
    end
    wait_idle();
    if (poke_busy) begin
      repeat (12) @(negedge clk);
      chk("R10 no extra frame", {31'h0, spi_ss_n}, 32'd1);
    end
    reg_read(2'd1, r);
    if (rx_exp) begin
      chk("R7 rx ready", {31'h0, r[1]}, 32'd1);
      reg_read(2'd3, r);
      chk("R7 rx word", {16'h0, r}, {16'h0, sw});
      peek(2'd1, r);
      chk("R8 ready cleared", {31'h0, r[1]}, 32'd0);
    end else begin
      chk("R9 rx ready off", {31'h0, r[1]}, 32'd0);
      reg_read(2'd3, r);
      chk("R9 rx word kept", {16'h0, r}, {16'h0, rx_old});
    end
  endtask

  initial begin
    logic [15:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ss_n", {31'h0, spi_ss_n}, 32'd1);
    chk("R1 sck", {31'h0, spi_sck}, 32'd0);
    chk("R1 mosi", {31'h0, spi_mosi}, 32'd0);
    peek(2'd1, r); chk("R1 status", {16'h0, r}, 32'd0);
    peek(2'd0, r); chk("R1 ctrl", {16'h0, r}, 32'd0);

    // All sections off: a transmit write must do nothing.
    reg_write(2'd2, 16'h1111);
    repeat (5) @(negedge clk);
    chk("R2 off no frame", {31'h0, spi_ss_n}, 32'd1);

    // Synchronisation window with DIV=1: ready after 8 clocks.
    set_ctrl(16'h0107);
    repeat (6) @(posedge clk);
    @(negedge clk);
    peek(2'd1, r); chk("R2 not ready yet", {31'h0, r[2]}, 32'd0);
    reg_write(2'd2, 16'h2222);
    peek(2'd1, r); chk("R2 not ready at 7", {31'h0, r[2]}, 32'd0);
    @(posedge clk); @(negedge clk);
    peek(2'd1, r); chk("R2 ready at 8", {31'h0, r[2]}, 32'd1);
    chk("R2 blocked write", {31'h0, spi_ss_n}, 32'd1);

    // Immediate-start frames.
    send(16'hA55A, 16'h3C96, 1, 16'h0, 0);
    send(16'h8001, 16'h7FFE, 1, 16'h0, 0);
    send(16'hFFFF, 16'h0000, 1, 16'h0, 0);
    // Late-start frames.
    set_ctrl(16'h010F);
    send(16'h1234, 16'hFEDC, 1, 16'h0, 0);
    send(16'h0000, 16'hFFFF, 1, 16'h0, 0);
    // Fastest divider, immediate.
    set_ctrl(16'h0007);
    send(16'h5AA5, 16'hC33C, 1, 16'h0, 0);
    // Slow divider, late.
    set_ctrl(16'h030F);
    send(16'hBEEF, 16'h1357, 1, 16'h0, 0);
    // Write during a frame.
    set_ctrl(16'h0107);
    send(16'h6B2D, 16'h9A0C, 1, 16'h0, 1);
    // Receive section held in reset.
    set_ctrl(16'h0105);
    send(16'h4C71, 16'h0F0F, 0, 16'h9A0C, 0);

    // Rate generator switched off in the middle of a frame.
    set_ctrl(16'h0107);
    abort_frame = 1;
    slv_word = 16'hAAAA;
    reg_write(2'd2, 16'h7777);
    repeat (9) @(negedge clk);
    set_ctrl(16'h0103);
    @(negedge clk);
    chk("R11 frame ended", {31'h0, spi_ss_n}, 32'd1);
    peek(2'd1, r);
    chk("R11 ready dropped", {29'h0, r[2:0]}, 32'd0);
    reg_write(2'd2, 16'h5555);
    repeat (10) @(negedge clk);
    chk("R11 no frame while off", {31'h0, spi_ss_n}, 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule